// File: doc/BRIEF.md
# Two-State 16-Bit External Bus Controller

This block converts single internal read and write requests into cycles on an external asynchronous 16-bit bus. Every cycle takes two bus states, T1 and T2, with no wait states. Each state is two clocks long, so strobes can switch at the middle of a state. The requester gives an address, a byte or word size, a direction, write data and an area number. The block then drives the address, one of eight active-low chip selects, an address strobe, a bus-start strobe, a read strobe, a direction line and two byte-lane write strobes.

Bytes are placed in big-endian order. An even byte address uses the upper lane, bits 15..8, and an odd byte address uses the lower lane, bits 7..0. A word must have an even address and uses both lanes. A word request with an odd address is refused with an error pulse. Read data is returned right-justified with a one-clock done pulse. The data pins are split into an output value, a per-lane output enable and an input value, so that the pad ring can make the tri-state buffers.

Top module: `xbus16_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every strobe and chip select is high, the direction line is high (read), both lane enables are 0 and req_ready is 1.
- R2: An accepted request produces exactly four clocks of bus cycle: T1 first half, T1 second half, T2 first half, T2 second half. rsp_done is high for the single clock that follows.
- R3: From the start of T1 to the end of T2, bus_addr and bus_rnw (1 = read) hold the request's values. Only bus_cs_n[area] is low during that time, and all chip selects are high at other times.
- R4: bus_bs_n is low only during the first half of T1.
- R5: On a read, bus_rd_n is low from the middle of T1 to the end of T2. bus_dq_i is sampled on the clock edge that ends T2.
- R6: bus_as_n is low from the middle of T1 to the middle of T2 (T1 second half and T2 first half).
- R7: A byte access to an even address uses the upper lane. A write drives bus_dq_o[15:8] with req_wdata[7:0], sets bus_dq_oe = 2'b10 and pulses only bus_wr_hi_n. A read returns {8'h00, bus_dq_i[15:8]}.
- R8: A byte access to an odd address uses the lower lane. A write drives bus_dq_o[7:0] with req_wdata[7:0], sets bus_dq_oe = 2'b01 and pulses only bus_wr_lo_n. A read returns {8'h00, bus_dq_i[7:0]}.
- R9: A word access at an even address uses both lanes. A write drives req_wdata unchanged, sets bus_dq_oe = 2'b11 and pulses both write strobes together. A read returns bus_dq_i unchanged.
- R10: A word request with address bit 0 set gives a one-clock rsp_err pulse in the clock after it is presented. No chip select or strobe goes active.
- R11: req_ready is low while a cycle is in progress, and a req_valid presented then is ignored.
- R12: The write strobes are low from the middle of T1 to the end of T2. The lane enables are set for the whole of T1 and T2 on writes only, and are 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken when req_ready is 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | AW | Byte address |
| req_area | input | log2(NAREA) | Area number selecting the chip select |
| req_wdata | input | 16 | Write data, right-justified for bytes |
| req_ready | output | 1 | Bus idle, a request can be taken |
| rsp_done | output | 1 | One-clock pulse after T2 |
| rsp_err | output | 1 | One-clock pulse for an odd word request |
| rsp_rdata | output | 16 | Read data, right-justified |
| bus_addr | output | AW | External address |
| bus_cs_n | output | NAREA | Active-low chip selects |
| bus_as_n | output | 1 | Address strobe |
| bus_bs_n | output | 1 | Bus start |
| bus_rd_n | output | 1 | Read strobe |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_wr_hi_n | output | 1 | Upper-lane write strobe |
| bus_wr_lo_n | output | 1 | Lower-lane write strobe |
| bus_dq_o | output | 16 | Data driven onto the bus |
| bus_dq_oe | output | 2 | Lane enables {upper, lower} |
| bus_dq_i | input | 16 | Data read from the bus |

## Verification
The hardest case to reach is a request presented while a cycle is already running. A well-behaved requester waits for req_ready, so it never does this. The bench deliberately holds req_valid high through the middle clocks of a read, and checks both that req_ready is low and that no extra bus-start appears afterwards. The monitor treats any bus-start with nothing queued as a failure. The odd-word refusal is also driven on its own, and the bench checks that only the error pulse results.

// File: rtl/xbus16_pkg.sv
package xbus16_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1A  = 3'd1,
    ST_T1B  = 3'd2,
    ST_T2A  = 3'd3,
    ST_T2B  = 3'd4,
    ST_DONE = 3'd5
  } bst_e;

  localparam int LANE_W = 8;
  localparam int DQ_W   = 16;
endpackage

// File: rtl/xbus16_fsm.sv
module xbus16_fsm
  import xbus16_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_word,
  input  logic req_a0,
  output bst_e st,
  output bst_e st_nxt,
  output logic accept,
  output logic reject
);
  logic idle;

  assign idle   = (st == ST_IDLE);
  assign reject = idle && req_valid && req_word && req_a0;
  assign accept = idle && req_valid && !(req_word && req_a0);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (accept) st_nxt = ST_T1A;
      ST_T1A:  st_nxt = ST_T1B;
      ST_T1B:  st_nxt = ST_T2A;
      ST_T2A:  st_nxt = ST_T2B;
      ST_T2B:  st_nxt = ST_DONE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end
endmodule

// File: rtl/xbus16_lanes.sv
module xbus16_lanes
  import xbus16_pkg::*;
(
  input  logic            word,
  input  logic            a0,
  input  logic [DQ_W-1:0] wdata,
  input  logic [DQ_W-1:0] din,
  output logic [1:0]      lane_en,
  output logic [DQ_W-1:0] dout,
  output logic [DQ_W-1:0] rdata
);
  localparam logic [LANE_W-1:0] ZB = '0;

  always_comb begin
    lane_en = {word | ~a0, word | a0};
    if (word) begin
      dout  = wdata;
      rdata = din;
    end else begin
      dout  = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
      rdata = a0 ? {ZB, din[LANE_W-1:0]} : {ZB, din[DQ_W-1:LANE_W]};
    end
  end
endmodule

// File: rtl/xbus16_csdec.sv
module xbus16_csdec #(
  parameter int NAREA  = 8,
  localparam int AREA_W = (NAREA > 1) ? $clog2(NAREA) : 1
) (
  input  logic              en,
  input  logic [AREA_W-1:0] area,
  output logic [NAREA-1:0]  cs_n
);
  for (genvar i = 0; i < NAREA; i++) begin : g_cs
    assign cs_n[i] = !(en && (area == AREA_W'(i)));
  end
endmodule

// File: rtl/xbus16_ctrl.sv
module xbus16_ctrl
  import xbus16_pkg::*;
#(
  parameter int AW     = 24,
  parameter int NAREA  = 8,
  localparam int AREA_W = (NAREA > 1) ? $clog2(NAREA) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [AW-1:0]     req_addr,
  input  logic [AREA_W-1:0] req_area,
  input  logic [15:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [15:0]       rsp_rdata,
  output logic [AW-1:0]     bus_addr,
  output logic [NAREA-1:0]  bus_cs_n,
  output logic              bus_as_n,
  output logic              bus_bs_n,
  output logic              bus_rd_n,
  output logic              bus_rnw,
  output logic              bus_wr_hi_n,
  output logic              bus_wr_lo_n,
  output logic [15:0]       bus_dq_o,
  output logic [1:0]        bus_dq_oe,
  input  logic [15:0]       bus_dq_i
);
  bst_e st, st_nxt;
  logic accept, reject;

  logic              lat_rnw, lat_word;
  logic [AREA_W-1:0] lat_area;
  logic [15:0]       lat_wdata;

  logic              cur_rnw, cur_word, cur_a0;
  logic [AREA_W-1:0] cur_area;
  logic [15:0]       cur_wdata;

  logic [1:0]        lane_en;
  logic [15:0]       lane_dout, lane_rdata;
  logic [NAREA-1:0]  cs_dec_n;
  logic              nxt_active, nxt_strobe, nxt_as;

  xbus16_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
    .req_a0(req_addr[0]), .st(st), .st_nxt(st_nxt),
    .accept(accept), .reject(reject)
  );

  // the request values are used at the edge that takes it, the latch after
  assign cur_rnw   = accept ? !req_write  : lat_rnw;
  assign cur_word  = accept ? req_word    : lat_word;
  assign cur_a0    = accept ? req_addr[0] : bus_addr[0];
  assign cur_area  = accept ? req_area    : lat_area;
  assign cur_wdata = accept ? req_wdata   : lat_wdata;

  xbus16_lanes u_lanes (
    .word(cur_word), .a0(cur_a0), .wdata(cur_wdata), .din(bus_dq_i),
    .lane_en(lane_en), .dout(lane_dout), .rdata(lane_rdata)
  );

  assign nxt_active = (st_nxt == ST_T1A) || (st_nxt == ST_T1B) ||
                      (st_nxt == ST_T2A) || (st_nxt == ST_T2B);
  assign nxt_strobe = (st_nxt == ST_T1B) || (st_nxt == ST_T2A) ||
                      (st_nxt == ST_T2B);
  assign nxt_as     = (st_nxt == ST_T1B) || (st_nxt == ST_T2A);

  xbus16_csdec #(.NAREA(NAREA)) u_cs (
    .en(nxt_active), .area(cur_area), .cs_n(cs_dec_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_rnw     <= 1'b1;
      lat_word    <= 1'b0;
      lat_area    <= '0;
      lat_wdata   <= '0;
      bus_addr    <= '0;
      req_ready   <= 1'b1;
      rsp_done    <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= '0;
      bus_cs_n    <= '1;
      bus_as_n    <= 1'b1;
      bus_bs_n    <= 1'b1;
      bus_rd_n    <= 1'b1;
      bus_rnw     <= 1'b1;
      bus_wr_hi_n <= 1'b1;
      bus_wr_lo_n <= 1'b1;
      bus_dq_o    <= '0;
      bus_dq_oe   <= '0;
    end else begin
      if (accept) begin
        lat_rnw   <= !req_write;
        lat_word  <= req_word;
        lat_area  <= req_area;
        lat_wdata <= req_wdata;
        bus_addr  <= req_addr;
      end
      req_ready   <= (st_nxt == ST_IDLE);
      rsp_done    <= (st_nxt == ST_DONE);
      rsp_err     <= reject;
      if (st == ST_T2B) rsp_rdata <= lane_rdata;
      bus_cs_n    <= cs_dec_n;
      bus_bs_n    <= !(st_nxt == ST_T1A);
      bus_as_n    <= !nxt_as;
      bus_rnw     <= nxt_active ? cur_rnw : 1'b1;
      bus_rd_n    <= !(nxt_strobe && cur_rnw);
      bus_wr_hi_n <= !(nxt_strobe && !cur_rnw && lane_en[1]);
      bus_wr_lo_n <= !(nxt_strobe && !cur_rnw && lane_en[0]);
      bus_dq_o    <= lane_dout;
      bus_dq_oe   <= (nxt_active && !cur_rnw) ? lane_en : 2'b00;
    end
  end
endmodule

// File: rtl/xbus16_chk.sv
module xbus16_chk #(
  parameter int AW    = 24,
  parameter int NAREA = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rsp_done,
  input logic             rsp_err,
  input logic [AW-1:0]    bus_addr,
  input logic [NAREA-1:0] bus_cs_n,
  input logic             bus_bs_n,
  input logic             bus_rd_n,
  input logic             bus_rnw,
  input logic             bus_wr_hi_n,
  input logic             bus_wr_lo_n,
  input logic [1:0]       bus_dq_oe
);
  // R3
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cs_n != '1 && $past(bus_cs_n != '1)) |-> $stable(bus_addr));
  // R2
  done_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_bs_n |-> ##4 rsp_done);
  // R4
  bs_single_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_bs_n |=> bus_bs_n);
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (bus_wr_hi_n && bus_wr_lo_n && bus_rnw));
  // R12
  oe_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_dq_oe != 2'b00) |-> (!bus_rnw && bus_cs_n != '1));
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (bus_cs_n == '1 && bus_bs_n && !rsp_done));
endmodule

bind xbus16_ctrl xbus16_chk #(.AW(AW), .NAREA(NAREA)) u_chk (
  .clk(clk), .rst(rst), .rsp_done(rsp_done), .rsp_err(rsp_err),
  .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_bs_n(bus_bs_n),
  .bus_rd_n(bus_rd_n), .bus_rnw(bus_rnw), .bus_wr_hi_n(bus_wr_hi_n),
  .bus_wr_lo_n(bus_wr_lo_n), .bus_dq_oe(bus_dq_oe)
);

// File: tb/sim_xbus16_ctrl.sv
`timescale 1ns/1ps
module sim_xbus16_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [2:0]  req_area = '0;
  logic [15:0] req_wdata = '0, bus_dq_i = '0;
  logic        req_ready, rsp_done, rsp_err;
  logic [15:0] rsp_rdata, bus_dq_o;
  logic [23:0] bus_addr;
  logic [7:0]  bus_cs_n;
  logic        bus_as_n, bus_bs_n, bus_rd_n, bus_rnw, bus_wr_hi_n, bus_wr_lo_n;
  logic [1:0]  bus_dq_oe;

  always #2 clk = ~clk;

  xbus16_ctrl u0 (.*);

  typedef struct {
    logic rnw; logic word; logic [23:0] addr; logic [2:0] area;
    logic [15:0] wd; logic [15:0] din;
  } item_t;
  item_t q[$];
  int nvec = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic rnw, input logic word, input logic [23:0] addr,
                       input logic [2:0] area, input logic [15:0] wd, input logic [15:0] din);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.rnw = rnw; it.word = word; it.addr = addr; it.area = area; it.wd = wd; it.din = din;
    q.push_back(it);
    bus_dq_i = din;
    req_write = !rnw; req_word = word; req_addr = addr; req_area = area; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops one expected item per bus-start and follows its four states
  initial begin
    item_t it;
    logic hi, lo, strobe;
    logic [15:0] er;
    forever begin
      @(negedge clk);
      if (!rst && bus_bs_n == 1'b0) begin
        if (q.size() == 0) begin
          chk("R11 unexpected bus cycle", 32'd1, 32'd0);
        end else begin
          it = q.pop_front();
          hi = it.word || !it.addr[0];
          lo = it.word || it.addr[0];
          for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            strobe = (k >= 1);
            chk("R4 bus start", {31'd0, bus_bs_n}, {31'd0, k != 0});
            chk("R6 address strobe", {31'd0, bus_as_n}, {31'd0, !(k == 1 || k == 2)});
            chk("R3 chip select", {24'd0, bus_cs_n}, {24'd0, ~(8'd1 << it.area)});
            chk("R3 address", {8'd0, bus_addr}, {8'd0, it.addr});
            chk("R3 direction", {31'd0, bus_rnw}, {31'd0, it.rnw});
            chk("R5 read strobe", {31'd0, bus_rd_n}, {31'd0, !(strobe && it.rnw)});
            chk("R12 upper write strobe", {31'd0, bus_wr_hi_n}, {31'd0, !(strobe && !it.rnw && hi)});
            chk("R12 lower write strobe", {31'd0, bus_wr_lo_n}, {31'd0, !(strobe && !it.rnw && lo)});
            chk("R12 lane enables", {30'd0, bus_dq_oe}, {30'd0, it.rnw ? 2'b00 : {hi, lo}});
            if (!it.rnw && hi)
              chk(it.word ? "R9 upper lane data" : "R7 upper lane data",
                  {24'd0, bus_dq_o[15:8]}, {24'd0, it.word ? it.wd[15:8] : it.wd[7:0]});
            if (!it.rnw && lo)
              chk(it.word ? "R9 lower lane data" : "R8 lower lane data",
                  {24'd0, bus_dq_o[7:0]}, {24'd0, it.wd[7:0]});
          end
          @(negedge clk);
          chk("R2 done pulse", {31'd0, rsp_done}, 32'd1);
          chk("R3 chip select released", {24'd0, bus_cs_n}, 32'h0000_00ff);
          chk("R12 lanes released", {30'd0, bus_dq_oe}, 32'd0);
          if (it.rnw) begin
            er = it.word ? it.din : (it.addr[0] ? {8'd0, it.din[7:0]} : {8'd0, it.din[15:8]});
            chk(it.word ? "R9 read data" : (it.addr[0] ? "R8 read data" : "R7 read data"),
                {16'd0, rsp_rdata}, {16'd0, er});
          end
          @(negedge clk);
          chk("R2 done is one clock", {31'd0, rsp_done}, 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  task automatic idle_chk(input string tag);
    chk({tag, " chip selects"}, {24'd0, bus_cs_n}, 32'h0000_00ff);
    chk({tag, " strobes"}, {27'd0, bus_as_n, bus_bs_n, bus_rd_n, bus_wr_hi_n, bus_wr_lo_n}, 32'h1f);
    chk({tag, " direction"}, {31'd0, bus_rnw}, 32'd1);
    chk({tag, " lane enables"}, {30'd0, bus_dq_oe}, 32'd0);
    chk({tag, " ready"}, {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    idle_chk("R1 after reset");

    // byte lanes, both directions, different areas
    issue(1'b0, 1'b0, 24'h000100, 3'd0, 16'h00a5, 16'h0000);  // R7 write even
    issue(1'b0, 1'b0, 24'h000101, 3'd7, 16'h003c, 16'h0000);  // R8 write odd
    issue(1'b0, 1'b1, 24'h00fffe, 3'd3, 16'hbeef, 16'h0000);  // R9 write word
    issue(1'b1, 1'b0, 24'h123456, 3'd1, 16'h0000, 16'h9a7e);  // R7 read even
    issue(1'b1, 1'b0, 24'h123457, 3'd6, 16'h0000, 16'h9a7e);  // R8 read odd
    issue(1'b1, 1'b1, 24'hfffffe, 3'd5, 16'h0000, 16'hc3d2);  // R9 read word

    // R10: odd word requests, write then read
    for (int d = 0; d < 2; d++) begin
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_write = (d == 0); req_word = 1'b1; req_addr = 24'h000203; req_area = 3'd2;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 error pulse", {31'd0, rsp_err}, 32'd1);
      chk("R10 no chip select", {24'd0, bus_cs_n}, 32'h0000_00ff);
      chk("R10 no bus start", {31'd0, bus_bs_n}, 32'd1);
      @(negedge clk);
      chk("R10 error is one clock", {31'd0, rsp_err}, 32'd0);
      chk("R10 still idle", {31'd0, req_ready}, 32'd1);
    end

    // R11: a request held high through a running read is ignored
    issue(1'b1, 1'b0, 24'h000040, 3'd4, 16'h0000, 16'h1234);
    @(negedge clk);
    chk("R11 ready low while busy", {31'd0, req_ready}, 32'd0);
    req_write = 1'b1; req_word = 1'b0; req_addr = 24'h000777; req_area = 3'd1;
    req_valid = 1'b1;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 nothing pending", q.size(), 32'd0);
    chk("R11 no extra cycle", {24'd0, bus_cs_n}, 32'h0000_00ff);

    // mixed patterns
    for (int i = 0; i < 16; i++) begin
      issue(i[0], i[1] & ~i[0], {8'h00, 8'(i * 37), 7'd0, i[2]} & {23'h7fffff, ~(i[1] & ~i[0])},
            3'(i), 16'(16'h1357 * (i + 1)), 16'(16'h2468 ^ (i * 16'h0101)));
    end

    while (q.size() != 0 || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule